// File: doc/BRIEF.md
# Headset jack and button controller

This block is the digital controller of a headset accessory detector. It watches a jack-detect level that reads high while the socket is empty and low once a plug is seated. It also reads a host mode level and the output of a comparator that goes active while the microphone line sits below the button threshold. From these it decides what the microphone bias switch and the bias regulator do, and it reports a debounced jack state and an active-low button-press flag.

There are three operating states. With a jack present and the host mode high, the block is in call mode: the regulator runs and the bias stays connected. With a jack present and the host mode low, it is in low-power mode: the regulator is shut down and the bias is switched on only for a short window at the start of each frame. Inside that window the comparator is read once, after a settling delay. With no jack, everything is off and the button flag is forced inactive. All times are parameters counted in clock cycles. The host mode level is assumed to be synchronous to the clock already. The jack and comparator inputs pass through two synchronising flops.

Top module: `hsd_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it, det_out is 1, swd_n is 1, ldo_on is 0 and bias_on is 0.
- R2: det_in is synchronised by two flops, then debounced. det_out changes only after the synchronised det_in has disagreed with det_out for JACK_DB consecutive cycles, so pulses shorter than that have no effect. det_out uses the same polarity as det_in: 1 means no jack, 0 means a jack is present.
- R3: In the cycle after det_out is 0 and mode_in is 1, ldo_on and bias_on are both 1, and they stay 1 continuously while that holds.
- R4: With det_out 0 and mode_in 0, ldo_on is 0 from the next cycle on. bias_on is 1 for the first WIN cycles of each LP_PERIOD-cycle frame and 0 for the rest. The first frame starts in the first low-power cycle.
- R5: One cycle after det_out is 1, ldo_on and bias_on are 0 whatever mode_in is. Two cycles after that, swd_n is 1.
- R6: Low-power mode is left in the cycle after mode_in goes high, provided a jack is present, and the block returns to call mode.
- R7: mic_cmp is synchronised by two flops. In call mode, swd_n goes to 0 after BTN_DB_CALL consecutive cycles of active comparator samples. It returns to 1 on the first inactive sample.
- R8: In low-power mode, the comparator is sampled only at cycle SETTLE of each frame, which lies inside the bias window. BTN_DB_LP consecutive active samples set swd_n to 0, and one inactive sample sets it back to 1. Comparator activity between samples has no effect.
- R9: When the block switches between call and low-power mode, the button debounce count restarts from zero. A press that is already being reported stays reported and is not dropped and raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_in | input | 1 | Raw jack detect, 1 = no jack, asynchronous |
| mode_in | input | 1 | Host mode level, 1 = call, 0 = standby, synchronous |
| mic_cmp | input | 1 | Microphone comparator, 1 = line below button threshold, asynchronous |
| det_out | output | 1 | Debounced jack state, 1 = no jack |
| swd_n | output | 1 | Button press, active low |
| ldo_on | output | 1 | Regulator enabled in low-noise operation, 0 = shutdown |
| bias_on | output | 1 | Microphone bias connection enable |

## Verification
A wrong jack debounce count shows up on det_out within a few cycles of the JACK_DB window, and one clock later on ldo_on and bias_on. A bad mode decision is visible on ldo_on in the very next cycle. A frame counter that drifts shows as a bias window that is misplaced or has the wrong width, at the latest by the second frame. Errors in button sampling or debounce show up as a fall or rise of swd_n that comes early or late. The worst case is one frame later in low-power mode, since only one sample is taken per frame. This is why the bench compares every output on every clock against its own model.

// File: rtl/hsd_pkg.sv
// Shared types for the headset controller.
package hsd_pkg;
    // Operating state of bias and regulator.
    typedef enum logic [1:0] {
        MD_OFF    = 2'd0,
        MD_CALL   = 2'd1,
        MD_LOWPWR = 2'd2
    } hsd_mode_t;
endpackage

// File: rtl/hsd_sync2.sv
// Two-flop synchroniser for W asynchronous levels.
// Assumes each bit is independent; RST_VAL gives the reset level per bit.
module hsd_sync2 #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Shift the inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/hsd_jack_debounce.sv
// Jack detect debouncer: adopts a new jack state only after the synchronised
// detect level has disagreed with the current state for JACK_DB cycles in a row.
// Assumes det_s is already synchronous; det_s = 1 means no jack.
module hsd_jack_debounce #(
    parameter int JACK_DB = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_s,
    output logic jack_present
);
    localparam int CW = $clog2(JACK_DB + 1);

    logic [CW-1:0] run_cnt;
    logic          raw_present;

    assign raw_present = ~det_s;

    // Count consecutive disagreeing cycles and flip state at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jack_present <= 1'b0;
            run_cnt      <= '0;
        end else if (raw_present != jack_present) begin
            if (run_cnt == CW'(JACK_DB - 1)) begin
                jack_present <= raw_present;
                run_cnt      <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/hsd_lp_timer.sv
// Low-power frame timer: counts LP_PERIOD-cycle frames while active, flags the
// bias window (first WIN cycles) and a one-cycle sample point at cycle SETTLE.
// Assumes SETTLE < WIN <= LP_PERIOD; the count restarts at 0 when inactive.
module hsd_lp_timer #(
    parameter int LP_PERIOD = 8000,
    parameter int WIN       = 100,
    parameter int SETTLE    = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic in_window,
    output logic sample_pt
);
    localparam int PW = $clog2(LP_PERIOD + 1);

    logic [PW-1:0] phase;

    // Advance the frame phase, wrapping each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase <= '0;
        end else if (phase == PW'(LP_PERIOD - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Decode window and sample point from the phase.
    always_comb begin
        in_window = active && (phase < PW'(WIN));
        sample_pt = active && (phase == PW'(SETTLE));
    end
endmodule

// File: rtl/hsd_button.sv
// Button press debouncer: counts consecutive active comparator samples and
// holds the press until an inactive sample. In call mode every cycle is a
// sample; in low-power mode only strobed cycles are. The count is cleared on
// a mode change, while an ongoing press is kept. Assumes mic_s is synchronous.
module hsd_button
    import hsd_pkg::*;
#(
    parameter int BTN_DB_CALL = 20000,
    parameter int BTN_DB_LP   = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  hsd_mode_t mode,
    input  logic      mode_chg,
    input  logic      lp_sample,
    input  logic      mic_s,
    output logic      pressed
);
    localparam int MAXDB = (BTN_DB_CALL > BTN_DB_LP) ? BTN_DB_CALL : BTN_DB_LP;
    localparam int BW    = $clog2(MAXDB + 1);

    logic [BW-1:0] hit_cnt;
    logic [BW-1:0] limit;
    logic          take;

    // Pick the sample strobe and the debounce limit for the current mode.
    always_comb begin
        take  = (mode == MD_CALL) || ((mode == MD_LOWPWR) && lp_sample);
        limit = (mode == MD_CALL) ? BW'(BTN_DB_CALL - 1) : BW'(BTN_DB_LP - 1);
    end

    // Debounce the press and clear it on release or when the jack is gone.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MD_OFF) begin
            hit_cnt <= '0;
            pressed <= 1'b0;
        end else if (mode_chg) begin
            hit_cnt <= '0;
        end else if (take) begin
            if (!mic_s) begin
                hit_cnt <= '0;
                pressed <= 1'b0;
            end else if (!pressed) begin
                if (hit_cnt == limit) begin
                    pressed <= 1'b1;
                    hit_cnt <= '0;
                end else begin
                    hit_cnt <= hit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hsd_ctrl.sv
// Headset jack and button controller top: synchronises the jack and
// comparator inputs, debounces the jack, selects call / low-power / off,
// drives regulator and bias enables and reports the button press.
// Assumes mode_in is synchronous to clk; reset is synchronous, active low.
module hsd_ctrl
    import hsd_pkg::*;
#(
    parameter int JACK_DB     = 10000,
    parameter int LP_PERIOD   = 8000,
    parameter int WIN         = 100,
    parameter int SETTLE      = 25,
    parameter int BTN_DB_CALL = 20000,
    parameter int BTN_DB_LP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_in,
    input  logic mode_in,
    input  logic mic_cmp,
    output logic det_out,
    output logic swd_n,
    output logic ldo_on,
    output logic bias_on
);
    logic [1:0] sync_out;
    logic       det_s, mic_s;
    logic       jack_present;
    hsd_mode_t  mode_q, mode_prev, mode_nxt;
    logic       lp_win, lp_sample;
    logic       pressed;

    hsd_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({mic_cmp, det_in}),
        .d_sync (sync_out)
    );
    assign det_s = sync_out[0];
    assign mic_s = sync_out[1];

    hsd_jack_debounce #(.JACK_DB(JACK_DB)) u_jack (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_s       (det_s),
        .jack_present(jack_present)
    );

    // Decide the operating state from jack and host mode.
    always_comb begin
        if (!jack_present)  mode_nxt = MD_OFF;
        else if (mode_in)   mode_nxt = MD_CALL;
        else                mode_nxt = MD_LOWPWR;
    end

    // Register the state and remember the previous one for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MD_OFF;
            mode_prev <= MD_OFF;
        end else begin
            mode_q    <= mode_nxt;
            mode_prev <= mode_q;
        end
    end

    hsd_lp_timer #(.LP_PERIOD(LP_PERIOD), .WIN(WIN), .SETTLE(SETTLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (mode_q == MD_LOWPWR),
        .in_window(lp_win),
        .sample_pt(lp_sample)
    );

    hsd_button #(.BTN_DB_CALL(BTN_DB_CALL), .BTN_DB_LP(BTN_DB_LP)) u_btn (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .mode_chg (mode_q != mode_prev),
        .lp_sample(lp_sample),
        .mic_s    (mic_s),
        .pressed  (pressed)
    );

    // Drive the outputs from registered state.
    always_comb begin
        det_out = ~jack_present;
        swd_n   = ~pressed;
        ldo_on  = (mode_q == MD_CALL);
        bias_on = (mode_q == MD_CALL) || lp_win;
    end
endmodule

// File: rtl/hsd_ctrl_chk.sv
// Port-level checker for hsd_ctrl, attached with bind.
// Assumes the reset is synchronous and JACK_DB is at least 2.
module hsd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic det_in,
    input logic mode_in,
    input logic mic_cmp,
    input logic det_out,
    input logic swd_n,
    input logic ldo_on,
    input logic bias_on
);
    // R2: a jack state change follows a synchronised level held two cycles.
    p_det_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(det_out) |-> (det_out == $past(det_in, 3)) && (det_out == $past(det_in, 4)));

    // R3 and R6: jack present with mode high gives call mode next cycle.
    p_call_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_out && mode_in) |=> (ldo_on && bias_on));

    // R4: jack present with mode low keeps the regulator off next cycle.
    p_lp_ldo_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_out && !mode_in) |=> !ldo_on);

    // R5: no jack gives everything off next cycle.
    p_nojack_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        det_out |=> (!ldo_on && !bias_on));

    // R5: with no jack held for three cycles, the button flag is inactive.
    p_nojack_swd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (det_out && $past(det_out) && $past(det_out, 2)) |-> swd_n);

    // R7: a press is raised only after an active comparator sample.
    p_press_needs_mic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swd_n) |-> $past(mic_cmp, 3));
endmodule

bind hsd_ctrl hsd_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .det_in (det_in),
    .mode_in(mode_in),
    .mic_cmp(mic_cmp),
    .det_out(det_out),
    .swd_n  (swd_n),
    .ldo_on (ldo_on),
    .bias_on(bias_on)
);

// File: tb/tb_hsd_ctrl.sv
`timescale 1ns/1ps
module tb_hsd_ctrl;
    localparam int JDB  = 6;
    localparam int PER  = 40;
    localparam int WN   = 8;
    localparam int STL  = 3;
    localparam int BDC  = 5;
    localparam int BDL  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_in = 1'b1;
    logic mode_in = 1'b0;
    logic mic_cmp = 1'b0;
    logic det_out, swd_n, ldo_on, bias_on;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsd_ctrl #(.JACK_DB(JDB), .LP_PERIOD(PER), .WIN(WN), .SETTLE(STL),
               .BTN_DB_CALL(BDC), .BTN_DB_LP(BDL)) dut (
        .clk(clk), .rst_n(rst_n), .det_in(det_in), .mode_in(mode_in),
        .mic_cmp(mic_cmp), .det_out(det_out), .swd_n(swd_n),
        .ldo_on(ldo_on), .bias_on(bias_on)
    );

    // Behavioural reference: queues model the input delay, integers the state.
    bit q_det[$];
    bit q_mic[$];
    int jack = 0;        // 1 = jack accepted
    int jrun = 0;        // cycles of disagreement seen
    int st = 0;          // 0 off, 1 call, 2 low power
    int st_old = 0;
    int frame = 0;
    int hits = 0;
    int held = 0;

    always @(posedge clk) begin
        bit d_seen, m_seen;
        int want, n_st, n_frame, n_jack, n_jrun, n_hits, n_held, lim;
        bit smp;
        cycles++;
        if (!rst_n) begin
            q_det = '{1'b1, 1'b1};
            q_mic = '{1'b0, 1'b0};
            jack = 0; jrun = 0; st = 0; st_old = 0; frame = 0; hits = 0; held = 0;
        end else begin
            d_seen = q_det.pop_front();
            q_det.push_back(det_in);
            m_seen = q_mic.pop_front();
            q_mic.push_back(mic_cmp);
            want = d_seen ? 0 : 1;
            n_jack = jack;
            n_jrun = 0;
            if (want != jack) begin
                n_jrun = jrun + 1;
                if (n_jrun >= JDB) begin
                    n_jack = want;
                    n_jrun = 0;
                end
            end
            n_st = (jack == 0) ? 0 : (mode_in ? 1 : 2);
            n_frame = (st == 2) ? (frame + 1) % PER : 0;
            n_hits = hits;
            n_held = held;
            smp = (st == 1) || (st == 2 && frame == STL);
            lim = (st == 1) ? BDC : BDL;
            if (st == 0) begin
                n_hits = 0; n_held = 0;
            end else if (st != st_old) begin
                n_hits = 0;
            end else if (smp) begin
                if (!m_seen) begin
                    n_hits = 0; n_held = 0;
                end else if (held == 0) begin
                    n_hits = hits + 1;
                    if (n_hits >= lim) begin
                        n_held = 1; n_hits = 0;
                    end
                end
            end
            st_old = st;
            jack = n_jack; jrun = n_jrun; st = n_st; frame = n_frame;
            hits = n_hits; held = n_held;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check("R2 det_out", det_out, jack == 0);
            check("R3 R5 R6 ldo_on", ldo_on, st == 1);
            check("R4 R5 bias_on", bias_on, (st == 1) || (st == 2 && frame < WN));
            check("R7 R8 R9 swd_n", swd_n, held == 0);
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog at cycle %0d: actual running expected finished", cycles);
            finish_run();
        end
    end

    initial begin
        wait_cycles(4);
        // R1: reset state.
        check("R1 det_out", det_out, 1'b1);
        check("R1 swd_n", swd_n, 1'b1);
        check("R1 ldo_on", ldo_on, 1'b0);
        check("R1 bias_on", bias_on, 1'b0);
        rst_n = 1'b1;
        wait_cycles(1);
        check("R1 after release", ldo_on | bias_on, 1'b0);
        wait_cycles(5);
        // R2: short glitch ignored, mode high with no jack (R5).
        mode_in = 1'b1;
        det_in = 1'b0; wait_cycles(JDB - 2); det_in = 1'b1;
        wait_cycles(15);
        check("R2 glitch ignored", det_out, 1'b1);
        mic_cmp = 1'b1; wait_cycles(20); mic_cmp = 1'b0;
        check("R5 button gated", swd_n, 1'b1);
        // R3: insert with mode high gives call mode.
        det_in = 1'b0;
        wait_cycles(JDB + 6);
        check("R3 call ldo", ldo_on, 1'b1);
        // R7: short press ignored, long press reported.
        mic_cmp = 1'b1; wait_cycles(BDC - 2); mic_cmp = 1'b0; wait_cycles(6);
        mic_cmp = 1'b1; wait_cycles(BDC + 8);
        check("R7 press reported", swd_n, 1'b0);
        mic_cmp = 1'b0; wait_cycles(6);
        check("R7 release", swd_n, 1'b1);
        // R4 and R8: low power, comparator toggling between samples.
        mode_in = 1'b0;
        for (int f = 0; f < 3; f++) begin
            wait_cycles(12); mic_cmp = 1'b1; wait_cycles(20); mic_cmp = 1'b0; wait_cycles(8);
        end
        check("R8 off-window activity ignored", swd_n, 1'b1);
        mic_cmp = 1'b1;
        wait_cycles(PER * (BDL + 1));
        check("R8 low power press", swd_n, 1'b0);
        // R9: press held across a mode change.
        mode_in = 1'b1; wait_cycles(3);
        check("R9 press kept", swd_n, 1'b0);
        mode_in = 1'b0; wait_cycles(PER + 5);
        mode_in = 1'b1; wait_cycles(2);
        mic_cmp = 1'b0; wait_cycles(5);
        // R9: a partial count is dropped at a mode change.
        mode_in = 1'b0; wait_cycles(PER - 10);
        mic_cmp = 1'b1; wait_cycles(PER + 5);
        mode_in = 1'b1; wait_cycles(BDC + 8);
        mic_cmp = 1'b0;
        // R6: leave low power, then R5: removal with mode toggling.
        mode_in = 1'b0; wait_cycles(17);
        mode_in = 1'b1; wait_cycles(2);
        check("R6 exit low power", ldo_on, 1'b1);
        mic_cmp = 1'b1; wait_cycles(BDC + 4);
        det_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wait_cycles(5); mode_in = ~mode_in;
        end
        wait_cycles(10);
        check("R5 removed ldo", ldo_on, 1'b0);
        check("R5 removed swd", swd_n, 1'b1);
        mic_cmp = 1'b0;
        wait_cycles(10);
        finish_run();
    end
endmodule